// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable cycle-level model of a synchronous static RAM. Reads and writes may follow each other in any order with no idle bus cycle. Every command is captured on a rising clock edge: the address, the direction, the chip enables, the per-byte write enables and the burst controls. A read's data leaves the part in a fixed pipeline slot. A write's data is taken in that same slot, so the shared data bus carries one transfer per cycle whichever way it runs.

A new access starts on a load cycle, when `step` is low. Each following cycle with `step` high continues it. A 2-bit counter then walks through the four words of the aligned group that holds the start address, in either linear or interleaved order. A hold input freezes the whole pipeline, the memory included. A small parameterised array stands in for the storage core. The tri-state data driver is modelled as a separate data output and an enable flag.

Top module: `zt_burst_sram`

## Requirements
- R1: After synchronous reset `rdata_oe` is 0 and the burst state is deselected, so a continuation cycle with `step`=1 before any load yields no access.
- R2: A load cycle (`step`=0) with all three chip enables active (`cs0_n`=0, `cs1`=1, `cs2_n`=0) and `wr_n`=1 is a read. The word is driven on `rdata` with `rdata_oe`=1 after the first enabled edge following the capture edge. The bus master samples it at the second enabled edge.
- R3: A selected load with `wr_n`=0 is a write. Its data is sampled from `wdata` at the second enabled edge after its address. `be_n` is active low, and bit i covers data bits [8i+7:8i]. `be_n` is sampled in every cycle of a burst, and bytes whose enable is inactive keep their stored value.
- R4: While `hold`=1, all inputs are ignored. No command is captured, no array byte changes, and `rdata` and `rdata_oe` stay unchanged. Pipeline latency counts only the edges with `hold`=0.
- R5: A cycle with `step`=1 advances the 2-bit burst count by one. The count wraps from 3 to 0 and never changes address bits above bit 1.
- R6: `ilv` is sampled on every enabled edge. With `ilv`=1 the low two address bits are the start offset XOR the count. With `ilv`=0 they are (start offset + count) mod 4.
- R7: A load with any chip enable inactive is a deselect. Continuation cycles after a deselect are also deselects.
- R8: A read whose address matches a write still waiting for its data returns that write's new bytes, merged byte by byte with the stored word.
- R9: For write and deselect cycles `rdata_oe` is 0, in the same pipeline slot that a read would drive.
- R10: Reads and writes may alternate on consecutive enabled cycles with no idle cycle, and every access completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | 1 freezes the pipeline and ignores all inputs |
| step | input | 1 | 0 loads a new address, 1 continues the burst |
| wr_n | input | 1 | Direction on a load: 0 write, 1 read |
| cs0_n | input | 1 | Chip enable, active low |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| be_n | input | NB (4) | Per-byte write enables, active low |
| addr | input | AW (6) | Word address |
| wdata | input | NB*BW (32) | Write data bus |
| rdata | output | NB*BW (32) | Read data bus |
| rdata_oe | output | 1 | High when `rdata` is driven |

## Verification
On a single edge a write can retire into the array while a read of the same word is being loaded into the output register. The bench provokes this by issuing a partial-byte write and a read of that address on consecutive load cycles, and also inside overlapping bursts and long random mixes. A hold input is sometimes placed between the two. The behavioural model applies the pending write to its own memory before it performs the read. The expected word is therefore the byte-wise merge, and it is compared with `rdata` after every edge.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits for a given burst start and count.
    function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] cnt,
                                                input logic       ilv);
        logic [1:0] sum;
        sum = 2'(start + cnt);
        return ilv ? (start ^ cnt) : sum;
    endfunction

    function automatic logic chip_selected(input logic cs0_n,
                                           input logic cs1,
                                           input logic cs2_n);
        return !cs0_n && cs1 && !cs2_n;
    endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
    import zt_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          step,
    input  logic          wr_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          ilv,
    input  logic [NB-1:0] be_n,
    input  logic [AW-1:0] addr,
    output op_e           cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic [NB-1:0] cmd_be,
    output op_e           burst_op,
    output logic [1:0]    burst_cnt,
    output logic [AW-1:0] burst_base
);

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } burst_t;

    burst_t cur_q, nxt;
    logic [AW-1:0] eff_addr;

    always_comb begin
        if (!step) begin
            nxt.base = addr;
            nxt.cnt  = 2'd0;
            if (!chip_selected(cs0_n, cs1, cs2_n)) nxt.op = OP_IDLE;
            else if (wr_n)                         nxt.op = OP_READ;
            else                                   nxt.op = OP_WRITE;
        end else begin
            nxt.base = cur_q.base;
            nxt.cnt  = 2'(cur_q.cnt + 2'd1);
            nxt.op   = cur_q.op;
        end
        eff_addr = {nxt.base[AW-1:2], burst_offset(nxt.base[1:0], nxt.cnt, ilv)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '{op: OP_IDLE, base: '0, cnt: 2'd0};
            cmd_op   <= OP_IDLE;
            cmd_addr <= '0;
            cmd_be   <= '0;
        end else if (!hold) begin
            cur_q    <= nxt;
            cmd_op   <= nxt.op;
            cmd_addr <= eff_addr;
            cmd_be   <= ~be_n;
        end
    end

    assign burst_op   = cur_q.op;
    assign burst_cnt  = cur_q.cnt;
    assign burst_base = cur_q.base;

endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB-1:0]    wr_be,
    input  logic [NB*BW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*BW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * BW;

    logic [DW-1:0] mem [DEPTH];
    logic          hit;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b]) mem[wr_addr][b*BW +: BW] <= wr_data[b*BW +: BW];
            end
        end
    end

    assign hit = wr_en && (wr_addr == rd_addr);

    // Byte-wise forwarding of a write retiring on the same edge.
    for (genvar g = 0; g < NB; g++) begin : g_merge
        assign rd_data[g*BW +: BW] = (hit && wr_be[g]) ? wr_data[g*BW +: BW]
                                                       : mem[rd_addr][g*BW +: BW];
    end

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
    import zt_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             step,
    input  logic             wr_n,
    input  logic             cs0_n,
    input  logic             cs1,
    input  logic             cs2_n,
    input  logic             ilv,
    input  logic [NB-1:0]    be_n,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata,
    output logic             rdata_oe
);
    localparam int DW = NB * BW;

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
    } stage_t;

    op_e           cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [NB-1:0] cmd_be;
    op_e           burst_op;
    logic [1:0]    burst_cnt;
    logic [AW-1:0] burst_base;
    stage_t        s2_q;
    logic [DW-1:0] core_rd;
    logic          core_wr;

    zt_burst_seq #(.AW(AW), .NB(NB)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .step       (step),
        .wr_n       (wr_n),
        .cs0_n      (cs0_n),
        .cs1        (cs1),
        .cs2_n      (cs2_n),
        .ilv        (ilv),
        .be_n       (be_n),
        .addr       (addr),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_be     (cmd_be),
        .burst_op   (burst_op),
        .burst_cnt  (burst_cnt),
        .burst_base (burst_base)
    );

    assign core_wr = (s2_q.op == OP_WRITE) && !hold;

    zt_sram_core #(.AW(AW), .NB(NB), .BW(BW)) u_core (
        .clk     (clk),
        .wr_en   (core_wr),
        .wr_addr (s2_q.addr),
        .wr_be   (s2_q.be),
        .wr_data (wdata),
        .rd_addr (cmd_addr),
        .rd_data (core_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q     <= '{op: OP_IDLE, addr: '0, be: '0};
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else if (!hold) begin
            s2_q     <= '{op: cmd_op, addr: cmd_addr, be: cmd_be};
            rdata_oe <= (cmd_op == OP_READ);
            if (cmd_op == OP_READ) rdata <= core_rd;
        end
    end

endmodule

// File: rtl/zt_burst_sram_chk.sv
module zt_burst_sram_chk
    import zt_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          hold,
    input logic          step,
    input op_e           cmd_op,
    input op_e           burst_op,
    input logic [1:0]    burst_cnt,
    input logic [AW-1:0] burst_base,
    input logic [DW-1:0] rdata,
    input logic          rdata_oe
);

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(rdata) && $stable(rdata_oe))); // R4

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!hold && cmd_op == OP_READ) |=> rdata_oe); // R2

    AST_NONREAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!hold && cmd_op != OP_READ) |=> !rdata_oe); // R9

    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!hold && step && burst_cnt == 2'd3) |=> (burst_cnt == 2'd0 && $stable(burst_base))); // R5

    AST_DESEL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!hold && step && burst_op == OP_IDLE) |=> (cmd_op == OP_IDLE)); // R7

endmodule

bind zt_burst_sram zt_burst_sram_chk #(.AW(AW), .DW(NB*BW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .step       (step),
    .cmd_op     (cmd_op),
    .burst_op   (burst_op),
    .burst_cnt  (burst_cnt),
    .burst_base (burst_base),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe)
);

// File: tb/zt_burst_sram_tb.sv
module zt_burst_sram_tb;
    localparam int AW    = 6;
    localparam int NB    = 4;
    localparam int BW    = 8;
    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          hold, step, wr_n, cs0_n, cs1, cs2_n, ilv;
    logic [NB-1:0] be_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    always #4 clk = ~clk;

    zt_burst_sram #(.AW(AW), .NB(NB), .BW(BW)) u_dut (
        .clk(clk), .rst(rst), .hold(hold), .step(step), .wr_n(wr_n),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .ilv(ilv), .be_n(be_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // Behavioural reference: 0 = none, 1 = read, 2 = write
    logic [DW-1:0] mmem [DEPTH];
    int            m_op, m_base, m_cnt;
    int            p1_op, p1_addr, p2_op, p2_addr;
    logic [NB-1:0] p1_be, p2_be;
    logic          exp_oe;
    logic [DW-1:0] exp_rd;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    task automatic model_reset();
        m_op = 0; m_base = 0; m_cnt = 0;
        p1_op = 0; p1_addr = 0; p1_be = '0;
        p2_op = 0; p2_addr = 0; p2_be = '0;
        exp_oe = 1'b0; exp_rd = '0;
    endtask

    task automatic model_step();
        int off;
        if (hold) return;
        if (p2_op == 2)
            for (int b = 0; b < NB; b++)
                if (p2_be[b]) mmem[p2_addr][b*BW +: BW] = wdata[b*BW +: BW];
        if (p1_op == 1) begin
            exp_oe = 1'b1;
            exp_rd = mmem[p1_addr];
        end else begin
            exp_oe = 1'b0;
        end
        p2_op = p1_op; p2_addr = p1_addr; p2_be = p1_be;
        if (!step) begin
            if (cs0_n || !cs1 || cs2_n) m_op = 0;
            else m_op = wr_n ? 1 : 2;
            m_base = int'(addr);
            m_cnt  = 0;
        end else begin
            m_cnt = (m_cnt + 1) % 4;
        end
        if (ilv) off = (m_base % 4) ^ m_cnt;
        else     off = ((m_base % 4) + m_cnt) % 4;
        p1_op   = m_op;
        p1_addr = (m_base / 4) * 4 + off;
        p1_be   = ~be_n;
    endtask

    task automatic compare();
        n_chk++;
        if (rdata_oe !== exp_oe || (exp_oe && rdata !== exp_rd)) begin
            n_fail++;
            $display("FAIL %s: oe=%0b rdata=%h expected oe=%0b rdata=%h",
                     cur_req, rdata_oe, rdata, exp_oe, exp_rd);
        end
    endtask

    task automatic cyc(input logic h, input logic s, input logic w,
                       input logic c0n, input logic c1, input logic c2n,
                       input logic il, input int a, input logic [NB-1:0] ben,
                       input string r);
        hold = h; step = s; wr_n = w; cs0_n = c0n; cs1 = c1; cs2_n = c2n;
        ilv = il; addr = AW'(a); be_n = ben; wdata = DW'($urandom);
        cur_req = r;
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare();
    endtask

    task automatic rd(input int a, input logic il, input string r);
        cyc(0, 0, 1, 0, 1, 0, il, a, '0, r);
    endtask
    task automatic wr(input int a, input logic [NB-1:0] ben, input string r);
        cyc(0, 0, 0, 0, 1, 0, 0, a, ben, r);
    endtask
    task automatic cont(input logic il, input logic [NB-1:0] ben, input string r);
        cyc(0, 1, 1, 0, 1, 0, il, int'($urandom % DEPTH), ben, r);
    endtask
    task automatic frz(input string r);
        cyc(1, $urandom % 2, $urandom % 2, 0, 1, 0, $urandom % 2,
            int'($urandom % DEPTH), NB'($urandom), r);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; hold = 0; step = 0; wr_n = 1; cs0_n = 1; cs1 = 0; cs2_n = 1;
        ilv = 0; addr = '0; be_n = '1; wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, then a continuation before any load
        compare();
        cont(0, '0, "R1");
        cont(1, '0, "R1");
        cyc(0, 0, 1, 1, 1, 0, 0, 0, '0, "R1");

        // R3 / R5 / R9: fill the array with full-word write bursts
        for (int g = 0; g < DEPTH / 4; g++) begin
            wr(g * 4, '0, "R3");
            for (int k = 0; k < 3; k++) cont(0, '0, "R9");
        end
        cyc(0, 0, 1, 1, 1, 0, 0, 0, '0, "R9");
        cyc(0, 0, 1, 1, 1, 0, 0, 0, '0, "R9");

        // R2 / R6: read bursts from every start offset, both orders
        for (int o = 0; o < 4; o++) begin
            for (int il = 0; il < 2; il++) begin
                rd(20 + o, il[0], "R2");
                for (int k = 0; k < 3; k++) cont(il[0], '0, "R6");
            end
        end

        // R5: continuation wraps twice inside one group
        rd(43, 0, "R5");
        for (int k = 0; k < 8; k++) cont(0, '0, "R5");

        // R3: partial byte writes, including per-beat enables in a burst
        wr(9, 4'b1010, "R3");
        wr(10, 4'b0111, "R3");
        wr(12, 4'b1110, "R3");
        cont(0, 4'b0101, "R3");
        cont(0, 4'b1111, "R3");
        cont(0, 4'b0011, "R3");
        rd(9, 0, "R3"); rd(10, 0, "R3");
        rd(12, 0, "R3"); cont(0, '0, "R3"); cont(0, '0, "R3"); cont(0, '0, "R3");

        // R8: read right behind a partial write to the same word
        wr(30, 4'b1001, "R8");
        rd(30, 0, "R8");
        wr(31, 4'b0110, "R8");
        frz("R8");
        rd(31, 0, "R8");
        wr(32, 4'b0000, "R8");
        cont(1, 4'b1100, "R8");
        rd(33, 1, "R8");
        cont(1, '0, "R8");
        rd(32, 0, "R8");

        // R10: strict read/write alternation with no idle cycle
        for (int k = 0; k < 24; k++) begin
            if (k % 2 == 0) wr(k % 16, NB'($urandom), "R10");
            else            rd((k - 1) % 16, 0, "R10");
        end

        // R4: hold inside read and write bursts
        rd(48, 1, "R4"); frz("R4"); frz("R4"); cont(1, '0, "R4");
        frz("R4"); cont(1, '0, "R4"); cont(1, '0, "R4");
        wr(52, '0, "R4"); frz("R4"); cont(0, 4'b0100, "R4"); frz("R4");
        frz("R4"); rd(52, 0, "R4"); cont(0, '0, "R4"); frz("R4"); cont(0, '0, "R4");

        // R7: each chip enable alone deselects, continuations stay deselected
        cyc(0, 0, 1, 1, 1, 0, 0, 5, '0, "R7"); cont(0, '0, "R7");
        cyc(0, 0, 0, 0, 0, 0, 0, 6, '0, "R7"); cont(0, '0, "R7");
        cyc(0, 0, 1, 0, 1, 1, 0, 7, '0, "R7"); cont(0, '0, "R7"); cont(0, '0, "R7");
        rd(5, 0, "R7");
        cont(0, '0, "R7");

        // R10: long random mix of every command kind
        for (int k = 0; k < 3000; k++) begin
            cyc(($urandom % 10) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
                ($urandom % 14) == 0, ($urandom % 14) != 0, ($urandom % 14) == 0,
                ($urandom % 2) == 0, int'($urandom % DEPTH), NB'($urandom), "R10");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule